// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This block sits on a small 16-bit register bus and decides which peripheral clocks may run and which peripherals are held in reset. The peripherals are split into bridge groups of up to sixteen channels each. Channel 0 of every group is that group's bridge clock, and the other channels are the children behind it. Software turns a single channel on by writing the channel's code to a set register, and turns it off by writing the same code to a clear register. Because the two registers are separate, no read-modify-write is needed and no other channel is touched.

Some channels are not under software control. A hardware-controlled channel follows a per-channel request input. An always-on channel cannot be gated at all. Each group also has a 16-bit reset register that is written as a whole value. The controller drives one clock-enable and one reset line per channel. The gating cells themselves sit outside the block.

Top module: `periph_clkrst_ctrl`

## Requirements
- R1: Writing code `{group[5:4], channel[3:0]}` to address 0 (set) turns on that software channel's own enable from the next cycle. All other channels keep their state.
- R2: Writing the same code to address 1 (clear) turns off that software channel's own enable from the next cycle. All other channels keep their state. If set and clear hit one channel together, clear wins.
- R3: A read of address 2+g returns group g's own enable states, with bit c holding channel c.
- R4: Address 5+g is group g's reset register. A write replaces all 16 bits, a read returns the current value, and `blk_rst_o[g*16+c]` equals bit c.
- R5: After reset, every reset bit is 1 and every software channel is off.
- R6: A hardware-controlled channel ignores set and clear writes. Its own enable equals its `hw_req` bit. The defaults are channels 0, 1, 16 and 32.
- R7: An always-on channel ignores clear and set writes and always reads back as enabled. The defaults are channels 12 and 38.
- R8: `clk_en_o` for channel 0 of a group equals its own enable. For any other channel it is the channel's own enable AND the group's channel-0 own enable.
- R9: Reads of addresses 0, 1 and any unmapped address return zero. Set and clear codes whose group field is 3 or more change nothing.
- R10: Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and reflects the state when the strobe was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| hw_req | input | 48 | Hardware gating requests, one per channel |
| clk_en_o | output | 48 | Per-channel clock enable after bridge gating |
| blk_rst_o | output | 48 | Per-channel reset, 1 holds the block in reset |

## Verification
The set and clear paths are tried in several ways. A child channel is turned on while its bridge is off, and then again while the bridge is running. Two channels in different groups are set one after the other. A single channel is cleared while its neighbours are on. Together these separate a correct single-bit update from a whole-register overwrite, and separate the own-enable status from the bridge-gated output. Set and clear writes aimed at hardware-controlled channels, at always-on channels and at an out-of-range group show whether each kind of write is really ignored. Reset-register writes with a mixed bit pattern and with all zeros check the bit order on the reset outputs.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;
    localparam int ADDR_SET = 0;
    localparam int ADDR_CLR = 1;
    localparam int ADDR_STAT_BASE = 2;

    function automatic int stat_addr(input int grp);
        return ADDR_STAT_BASE + grp;
    endfunction

    function automatic int rst_addr(input int grp, input int n_grps);
        return ADDR_STAT_BASE + n_grps + grp;
    endfunction
endpackage

// File: rtl/pcrc_decode.sv
module pcrc_decode #(
    parameter int GRPS = 3,
    parameter int CHS  = 16,
    parameter int AW   = 4,
    localparam int GRP_W  = $clog2(GRPS),
    localparam int CH_W   = $clog2(CHS),
    localparam int CODE_W = GRP_W + CH_W,
    localparam int TOT    = GRPS * CHS
) (
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [CODE_W-1:0] code,
    output logic [TOT-1:0]    set_v,
    output logic [TOT-1:0]    clr_v,
    output logic [GRPS-1:0]   rst_we
);
    import pcrc_pkg::*;

    logic [GRP_W-1:0] grp_f;
    logic [CH_W-1:0]  ch_f;
    logic             is_set;
    logic             is_clr;

    assign grp_f  = code[CODE_W-1:CH_W];
    assign ch_f   = code[CH_W-1:0];
    assign is_set = bus_wr && (int'(bus_addr) == ADDR_SET);
    assign is_clr = bus_wr && (int'(bus_addr) == ADDR_CLR);

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int g = 0; g < GRPS; g++) begin
            for (int c = 0; c < CHS; c++) begin
                if ((int'(grp_f) == g) && (int'(ch_f) == c)) begin
                    set_v[g*CHS + c] = is_set;
                    clr_v[g*CHS + c] = is_clr;
                end
            end
        end
    end

    always_comb begin
        for (int g = 0; g < GRPS; g++) begin
            rst_we[g] = bus_wr && (int'(bus_addr) == rst_addr(g, GRPS));
        end
    end
endmodule

// File: rtl/pcrc_gate_bank.sv
module pcrc_gate_bank #(
    parameter int CHS = 16,
    parameter logic [CHS-1:0] HW_MASK = '0,
    parameter logic [CHS-1:0] ON_MASK = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CHS-1:0] set_v,
    input  logic [CHS-1:0] clr_v,
    input  logic [CHS-1:0] hw_req,
    output logic [CHS-1:0] own_on,
    output logic [CHS-1:0] clk_en
);
    typedef struct packed {
        logic [CHS-1:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < CHS; c++) begin
            if (!HW_MASK[c] && !ON_MASK[c]) begin
                if (clr_v[c]) begin
                    bank_d.en[c] = 1'b0;
                end else if (set_v[c]) begin
                    bank_d.en[c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        for (int c = 0; c < CHS; c++) begin
            if (ON_MASK[c]) begin
                own_on[c] = 1'b1;
            end else if (HW_MASK[c]) begin
                own_on[c] = hw_req[c];
            end else begin
                own_on[c] = bank_q.en[c];
            end
        end
    end

    always_comb begin
        clk_en[0] = own_on[0];
        for (int c = 1; c < CHS; c++) begin
            clk_en[c] = own_on[c] & own_on[0];
        end
    end

    for (genvar c = 0; c < CHS; c++) begin : g_sw_chk
        if (!HW_MASK[c] && !ON_MASK[c]) begin : g_sw
            AST_SET_TURNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
                (set_v[c] && !clr_v[c]) |=> own_on[c]); // R1
            AST_CLR_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                clr_v[c] |=> !own_on[c]); // R2
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_v[c] && !clr_v[c]) |=> $stable(own_on[c])); // R1
        end
        if (ON_MASK[c]) begin : g_on
            AST_ALWAYS_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
                own_on[0] |-> clk_en[c]); // R7
        end
    end
endmodule

// File: rtl/periph_clkrst_ctrl.sv
module periph_clkrst_ctrl #(
    parameter int GRPS = 3,
    parameter int CHS  = 16,
    parameter int DW   = 16,
    parameter int AW   = 4,
    parameter logic [GRPS*CHS-1:0] HW_MASK = 48'h0001_0001_0003,
    parameter logic [GRPS*CHS-1:0] ON_MASK = 48'h0040_0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic                bus_rd,
    output logic [DW-1:0]       bus_rdata,
    input  logic [GRPS*CHS-1:0] hw_req,
    output logic [GRPS*CHS-1:0] clk_en_o,
    output logic [GRPS*CHS-1:0] blk_rst_o
);
    import pcrc_pkg::*;

    localparam int TOT    = GRPS * CHS;
    localparam int CODE_W = $clog2(GRPS) + $clog2(CHS);

    typedef struct packed {
        logic [GRPS-1:0][DW-1:0] rst;
        logic [DW-1:0]           rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [TOT-1:0]  set_v;
    logic [TOT-1:0]  clr_v;
    logic [GRPS-1:0] rst_we;
    logic [TOT-1:0]  own_on;

    pcrc_decode #(.GRPS(GRPS), .CHS(CHS), .AW(AW)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .code     (bus_wdata[CODE_W-1:0]),
        .set_v    (set_v),
        .clr_v    (clr_v),
        .rst_we   (rst_we)
    );

    for (genvar g = 0; g < GRPS; g++) begin : g_bank
        pcrc_gate_bank #(
            .CHS     (CHS),
            .HW_MASK (HW_MASK[g*CHS +: CHS]),
            .ON_MASK (ON_MASK[g*CHS +: CHS])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_v  (set_v[g*CHS +: CHS]),
            .clr_v  (clr_v[g*CHS +: CHS]),
            .hw_req (hw_req[g*CHS +: CHS]),
            .own_on (own_on[g*CHS +: CHS]),
            .clk_en (clk_en_o[g*CHS +: CHS])
        );
    end

    always_comb begin
        regs_d = regs_q;
        for (int g = 0; g < GRPS; g++) begin
            if (rst_we[g]) begin
                regs_d.rst[g] = bus_wdata;
            end
        end
        if (bus_rd) begin
            regs_d.rdata = '0;
            for (int g = 0; g < GRPS; g++) begin
                if (int'(bus_addr) == stat_addr(g)) begin
                    regs_d.rdata[CHS-1:0] = own_on[g*CHS +: CHS];
                end
                if (int'(bus_addr) == rst_addr(g, GRPS)) begin
                    regs_d.rdata = regs_q.rst[g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.rst   <= '1;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;

    always_comb begin
        for (int g = 0; g < GRPS; g++) begin
            for (int c = 0; c < CHS; c++) begin
                blk_rst_o[g*CHS + c] = regs_q.rst[g][c];
            end
        end
    end

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(blk_rst_o)); // R4
    AST_RST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == rst_addr(0, GRPS))
        |=> (blk_rst_o[CHS-1:0] == $past(bus_wdata[CHS-1:0]))); // R4
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (int'(bus_addr) == ADDR_SET || int'(bus_addr) == ADDR_CLR))
        |=> (bus_rdata == '0)); // R9
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) == stat_addr(0))
        |=> (bus_rdata[CHS-1:0] == $past(own_on[CHS-1:0]))); // R3
endmodule

// File: tb/periph_clkrst_ctrl_test.sv
`timescale 1ns/1ps
module periph_clkrst_ctrl_test;
    localparam logic [47:0] HWM = 48'h0001_0001_0003;
    localparam logic [47:0] ONM = 48'h0040_0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [47:0] hw_req = '0;
    logic [47:0] clk_en_o;
    logic [47:0] blk_rst_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [47:0]      sw_m = '0;
    logic [2:0][15:0] rst_m = '1;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    periph_clkrst_ctrl #(.HW_MASK(HWM), .ON_MASK(ONM)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .clk_en_o(clk_en_o), .blk_rst_o(blk_rst_o)
    );

    function automatic logic own_exp(input int i);
        if (ONM[i]) return 1'b1;
        if (HWM[i]) return hw_req[i];
        return sw_m[i];
    endfunction

    function automatic logic [47:0] clk_exp();
        logic [47:0] r;
        for (int i = 0; i < 48; i++) begin
            r[i] = own_exp(i) & ((i % 16 == 0) ? 1'b1 : own_exp((i / 16) * 16));
        end
        return r;
    endfunction

    function automatic logic [15:0] stat_exp(input int g);
        logic [15:0] r;
        for (int c = 0; c < 16; c++) r[c] = own_exp(g * 16 + c);
        return r;
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 4'd0 || a == 4'd1) begin
            if (d[5:4] < 2'd3 && !HWM[d[5:0]] && !ONM[d[5:0]]) sw_m[d[5:0]] = (a == 4'd0);
        end else if (a >= 4'd5 && a <= 4'd7) begin
            rst_m[a - 4'd5] = d;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin : monitor
        logic got;
        forever begin
            @(posedge clk);
            got = bus_rd;
            @(negedge clk);
            if (got && exp_q.size() > 0) begin
                check(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset outputs", blk_rst_o, '1);
        check("R5 R7 R8 clk_en after reset", clk_en_o, clk_exp());
        rd(4'd2, 16'h1000, "R5 R7 R10 status g0 after reset");
        rd(4'd4, 16'h0040, "R7 status g2 always-on");
        rd(4'd6, 16'hFFFF, "R4 R5 rst g1 after reset");

        wr(4'd0, 16'h0013);
        rd(4'd3, stat_exp(1), "R1 set ch19");
        check("R8 child gated by bridge off", clk_en_o, clk_exp());

        @(negedge clk); hw_req[16] = 1'b1;
        @(negedge clk);
        check("R6 R8 bridge hw on opens child", clk_en_o, clk_exp());
        rd(4'd3, 16'h0009, "R6 status g1 hw bridge");

        wr(4'd0, 16'h0025);
        wr(4'd0, 16'h0014);
        rd(4'd3, 16'h0019, "R1 second set keeps others");
        rd(4'd4, 16'h0060, "R1 set g2 ch5");

        wr(4'd1, 16'h0013);
        rd(4'd3, 16'h0011, "R2 clear only ch19");
        check("R2 R8 clk_en after clear", clk_en_o, clk_exp());

        @(negedge clk); hw_req[16] = 1'b0; hw_req[0] = 1'b1;
        wr(4'd0, 16'h0010);
        rd(4'd3, 16'h0010, "R6 set on hw channel ignored");
        wr(4'd1, 16'h0000);
        rd(4'd2, 16'h1001, "R6 clear on hw channel ignored");

        wr(4'd1, 16'h000C);
        rd(4'd2, 16'h1001, "R7 clear on always-on ignored");
        check("R7 R8 always-on child passes with bridge", clk_en_o, clk_exp());

        wr(4'd0, 16'h0033);
        rd(4'd2, stat_exp(0), "R9 bad group g0");
        rd(4'd3, stat_exp(1), "R9 bad group g1");
        rd(4'd4, stat_exp(2), "R9 bad group g2");
        rd(4'd0, 16'h0000, "R9 read set reg");
        rd(4'd1, 16'h0000, "R9 read clear reg");
        rd(4'd15, 16'h0000, "R9 read unmapped");

        wr(4'd5, 16'hA5A5);
        check("R4 rst outputs g0 pattern", blk_rst_o, {rst_m[2], rst_m[1], rst_m[0]});
        rd(4'd5, 16'hA5A5, "R4 R10 rst g0 readback");
        wr(4'd7, 16'h0000);
        check("R4 rst outputs g2 released", blk_rst_o, {rst_m[2], rst_m[1], rst_m[0]});
        rd(4'd7, 16'h0000, "R4 rst g2 readback");
        rd(4'd6, 16'hFFFF, "R4 rst g1 untouched");
        check("R8 final clk_en", clk_en_o, clk_exp());

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule